// File: doc/BRIEF.md
# Prescaled General Purpose Timer

This block is a down-timing peripheral with a small register window. Software programs a prescaler and a period in a single count word. It then writes a control word that selects the timer function and turns the counter on. The bus clock is divided by the prescaler to form ticks. After the programmed number of ticks the timer expires and sets a sticky status flag. When the interrupt enable is set, that flag drives the interrupt line.

A control bit chooses between two behaviours on expiry. In one-shot mode the timer stops and clears its own enable. In continuous mode it reloads and starts the next period at once. A count word written while the timer runs is held back and only takes effect at the next reload, so a period already under way keeps its length. Both the prescaler and the period count are one-based, and a field value of zero stands for the full 65536.

Top module: `pgt_timer`

## Requirements
- R1: After reset the control, count and status registers all read zero and irq_o is low.
- R2: The control register (byte offset 0x0, address bits 3:2 = 0) keeps only bit 12 (enable), bit 10 (continuous), bit 9 (open-drain, stored only), bit 8 (interrupt enable) and bits 2:0 (function select), and every other bit reads zero. The count register (offset 0x4) reads back the whole word. Offset 0xC reads zero.
- R3: The timer counts only while the enable bit is set and the function select holds 4. With any other select value it never expires, and the control register keeps the value written to it.
- R4: The count word holds the prescaler P in bits 31:16 and the period C in bits 15:0. Counting starts after the clock edge that writes enable. Expiry then comes P*C clock edges later, and P = 0 counts as 65536.
- R5: A period field C = 0 counts as 65536 ticks.
- R6: In one-shot mode (bit 10 clear), expiry clears the enable bit and the timer does not expire again. The other control bits are kept.
- R7: In continuous mode (bit 10 set), each expiry reloads the prescaler and the period, and the timer expires again one full period later.
- R8: A count write made while the timer runs does not change the current period. It applies from the next reload, and the count register reads back the new value at once.
- R9: Status bit 0 (offset 0x8) sets on expiry and stays set. Writing 1 to it clears it, and writing 0 has no effect. If an expiry and a clear fall on the same edge, the flag stays set.
- R10: irq_o is high exactly when status bit 0 and control bit 8 are both set. With bit 8 clear the flag still sets, and setting bit 8 later raises irq_o.
- R11: Clearing the enable bit stops the timer part way through a period. Setting it again starts a full new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, also the timer source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte address of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Interrupt request, level |

## Verification
The bench builds the timer with its default 16-bit prescaler and 16-bit period. With those widths, the wrap of a zero field to 65536 is a real 65536-edge wait: one run with P = 0 and one with C = 0 fit within the cycle budget. Small values of P and C cover the other cases. These include one-shot stop, continuous reload with a count rewrite in mid-period, W1C behaviour, interrupt masking and a stop and restart, where the exact expiry edge is predicted for each.

// File: rtl/pgt_pkg.sv
package pgt_pkg;
  localparam int unsigned MODE_EN_BIT   = 12;
  localparam int unsigned MODE_CONT_BIT = 10;
  localparam int unsigned MODE_OD_BIT   = 9;
  localparam int unsigned MODE_IRQ_BIT  = 8;
  localparam int unsigned MODE_MS_W     = 3;
  localparam logic [MODE_MS_W-1:0] MS_TIMER = 3'd4;

  typedef enum logic [1:0] {
    SEL_MODE   = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pgt_divstage.sv
// Up-counter that wraps when it reaches limit-1; limit 0 means 2**W.
module pgt_divstage #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         step_i,
  input  logic [W-1:0] limit_i,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] last;

  assign last   = limit_i - W'(1);
  assign wrap_o = run_i && step_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (wrap_o)     cnt_q <= '0;
    else if (step_i)     cnt_q <= cnt_q + W'(1);
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));

  // R4
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && limit_i != '0 && $stable(limit_i)) |-> (cnt_q < limit_i));
endmodule

// File: rtl/pgt_regs.sv
module pgt_regs
  import pgt_pkg::*;
#(
  parameter int unsigned PRE_W = 16,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  reg_sel_e         sel_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic             expire_i,
  output logic             run_o,
  output logic             cont_o,
  output logic             irq_en_o,
  output logic [PRE_W-1:0] pre_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o
);
  localparam int unsigned CW = PRE_W + CNT_W;

  logic                 en_q, cont_q, od_q, irq_q, flag_q;
  logic [MODE_MS_W-1:0] ms_q;
  logic [CW-1:0]        count_q;
  logic                 mode_wr, count_wr, clr_req;

  assign mode_wr  = we_i && (sel_i == SEL_MODE);
  assign count_wr = we_i && (sel_i == SEL_COUNT);
  assign clr_req  = we_i && (sel_i == SEL_STATUS) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      cont_q <= 1'b0;
      od_q   <= 1'b0;
      irq_q  <= 1'b0;
      ms_q   <= '0;
    end else if (mode_wr) begin
      en_q   <= wdata_i[MODE_EN_BIT];
      cont_q <= wdata_i[MODE_CONT_BIT];
      od_q   <= wdata_i[MODE_OD_BIT];
      irq_q  <= wdata_i[MODE_IRQ_BIT];
      ms_q   <= wdata_i[MODE_MS_W-1:0];
    end else if (expire_i && !cont_q) begin
      en_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        count_q <= '0;
    else if (count_wr)  count_q <= wdata_i[CW-1:0];
  end

  // Set has priority over a same-edge clear.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (expire_i) flag_q <= 1'b1;
    else if (clr_req)  flag_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      SEL_MODE: begin
        rdata_o[MODE_EN_BIT]     = en_q;
        rdata_o[MODE_CONT_BIT]   = cont_q;
        rdata_o[MODE_OD_BIT]     = od_q;
        rdata_o[MODE_IRQ_BIT]    = irq_q;
        rdata_o[MODE_MS_W-1:0]   = ms_q;
      end
      SEL_COUNT:  rdata_o[CW-1:0] = count_q;
      SEL_STATUS: rdata_o[0]      = flag_q;
      default:    rdata_o         = '0;
    endcase
  end

  assign run_o    = en_q && (ms_q == MS_TIMER);
  assign cont_o   = cont_q;
  assign irq_en_o = irq_q;
  assign pre_o    = count_q[CW-1:CNT_W];
  assign cnt_o    = count_q[CNT_W-1:0];
  assign flag_o   = flag_q;

  // R6
  one_shot_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && !cont_q && !mode_wr) |=> !en_q);

  // R9
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_req) |=> flag_q);

  // R9
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> flag_q);
endmodule

// File: rtl/pgt_timer.sv
module pgt_timer
  import pgt_pkg::*;
#(
  parameter int unsigned PRE_W  = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o
);
  localparam int unsigned HI_W = ADDR_W - 4;

  reg_sel_e         sel;
  logic             run, cont, irq_en, flag, tick, expire, reload;
  logic [PRE_W-1:0] pre_reg, act_pre_q;
  logic [CNT_W-1:0] cnt_reg, act_cnt_q;

  generate
    if (HI_W > 0) begin : g_hi_dec
      assign sel = (reg_addr_i[ADDR_W-1:4] == '0) ? reg_sel_e'(reg_addr_i[3:2]) : SEL_NONE;
    end else begin : g_flat_dec
      assign sel = reg_sel_e'(reg_addr_i[3:2]);
    end
  endgenerate

  pgt_regs #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .sel_i    (sel),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .expire_i (expire),
    .run_o    (run),
    .cont_o   (cont),
    .irq_en_o (irq_en),
    .pre_o    (pre_reg),
    .cnt_o    (cnt_reg),
    .flag_o   (flag)
  );

  // Working copy: follows the register while idle, refreshed only on reload.
  assign reload = !run || (expire && cont);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_pre_q <= '0;
      act_cnt_q <= '0;
    end else if (reload) begin
      act_pre_q <= pre_reg;
      act_cnt_q <= cnt_reg;
    end
  end

  pgt_divstage #(.W(PRE_W)) u_prescale (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .step_i  (1'b1),
    .limit_i (act_pre_q),
    .wrap_o  (tick)
  );

  pgt_divstage #(.W(CNT_W)) u_period (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .step_i  (tick),
    .limit_i (act_cnt_q),
    .wrap_o  (expire)
  );

  assign irq_o = flag && irq_en;

  // R8
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !expire) |=> ($stable(act_pre_q) && $stable(act_cnt_q)));

  // R7
  cont_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && cont && !(reg_we_i && sel == SEL_MODE)) |=> run);

  // R3
  expire_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |-> (run && tick));
endmodule

// File: tb/pgt_timer_bench.sv
module pgt_timer_bench;
  localparam logic [3:0] A_MODE = 4'h0, A_COUNT = 4'h4, A_STATUS = 4'h8, A_NONE = 4'hC;

  typedef struct {
    int    cyc;
    logic  irq;
    logic  flag;
    string tag;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = A_STATUS;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int   cyc = 0;
  int   vectors = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t q[$];
  exp_t it;

  pgt_timer u_pgt_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o)
  );

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  // Monitor: pop items due at this cycle and compare.
  always @(negedge clk_i) begin
    while (q.size() > 0 && q[0].cyc == cyc) begin
      it = q.pop_front();
      vectors++;
      if (irq_o !== it.irq || reg_rdata_o[0] !== it.flag) begin
        errors++;
        $display("FAIL %s cyc=%0d irq=%0b flag=%0b expected irq=%0b flag=%0b",
                 it.tag, cyc, irq_o, reg_rdata_o[0], it.irq, it.flag);
      end
    end
  end

  task automatic push(input int c, input logic ei, input logic ef, input string tag);
    exp_t e;
    e.cyc = c; e.irq = ei; e.flag = ef; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, output int edge_n);
    @(posedge clk_i); #1;
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); #1;
    edge_n = cyc;
    reg_we_i = 1'b0; reg_addr_i = A_STATUS;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk_i);
    @(posedge clk_i);
  endtask

  task automatic chk_reg(input logic [3:0] a, input logic [31:0] exp_v, input string tag);
    @(posedge clk_i); #1;
    reg_addr_i = a; #1;
    vectors++;
    if (reg_rdata_o !== exp_v) begin
      errors++;
      $display("FAIL %s addr=%h read=%h expected=%h", tag, a, reg_rdata_o, exp_v);
    end
    reg_addr_i = A_STATUS;
  endtask

  task automatic chk_irq(input logic exp_v, input string tag);
    #1;
    vectors++;
    if (irq_o !== exp_v) begin
      errors++;
      $display("FAIL %s irq=%0b expected=%0b", tag, irq_o, exp_v);
    end
  endtask

  initial begin
    repeat (199000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at cyc=%0d", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int e, e0, e1, e2, e3, es, er;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset state
    chk_reg(A_MODE,   32'h0, "R1");
    chk_reg(A_COUNT,  32'h0, "R1");
    chk_reg(A_STATUS, 32'h0, "R1");
    chk_irq(1'b0, "R1");

    // R2 stored bits and readback
    wr(A_MODE, 32'hFFFF_FFFF, e);
    chk_reg(A_MODE, 32'h0000_1707, "R2");
    wr(A_COUNT, 32'hA5A5_5A5A, e);
    chk_reg(A_COUNT, 32'hA5A5_5A5A, "R2");
    chk_reg(A_NONE, 32'h0, "R2");
    wr(A_MODE, 32'h0, e);

    // R3 wrong function select never expires
    wr(A_COUNT, {16'd2, 16'd3}, e);
    wr(A_MODE, 32'h0000_1101, e);
    push(e + 6, 1'b0, 1'b0, "R3");
    push(e + 20, 1'b0, 1'b0, "R3");
    drain();
    chk_reg(A_MODE, 32'h0000_1101, "R3");

    // R4 / R6 one-shot, P=2 C=3 -> 6 edges
    wr(A_MODE, 32'h0000_1104, e);
    push(e + 5, 1'b0, 1'b0, "R4");
    push(e + 6, 1'b1, 1'b1, "R4");
    push(e + 20, 1'b1, 1'b1, "R6");
    drain();
    chk_reg(A_MODE, 32'h0000_0104, "R6");

    // R9 write 0 keeps, write 1 clears
    wr(A_STATUS, 32'h0, e);
    push(e + 1, 1'b1, 1'b1, "R9");
    drain();
    wr(A_STATUS, 32'h1, e);
    push(e + 1, 1'b0, 1'b0, "R9");
    drain();

    // R10 masked interrupt, P=1 C=4
    wr(A_COUNT, {16'd1, 16'd4}, e);
    wr(A_MODE, 32'h0000_1004, e);
    push(e + 3, 1'b0, 1'b0, "R10");
    push(e + 4, 1'b0, 1'b1, "R10");
    drain();
    wr(A_MODE, 32'h0000_0104, e);
    push(e + 1, 1'b1, 1'b1, "R10");
    drain();
    wr(A_STATUS, 32'h1, e);

    // R7 / R8 continuous with mid-period rewrite
    wr(A_COUNT, {16'd1, 16'd5}, e);
    wr(A_MODE, 32'h0000_1504, e0);
    push(e0 + 4, 1'b0, 1'b0, "R8");
    push(e0 + 5, 1'b1, 1'b1, "R8");
    wr(A_COUNT, {16'd1, 16'd6}, e1);
    drain();
    wr(A_STATUS, 32'h1, e2);
    push(e2 + 1, 1'b0, 1'b0, "R9");
    push(e0 + 10, 1'b0, 1'b0, "R8");
    push(e0 + 11, 1'b1, 1'b1, "R8");
    drain();
    wr(A_STATUS, 32'h1, e3);
    push(e3 + 1, 1'b0, 1'b0, "R7");
    push(e0 + 16, 1'b0, 1'b0, "R7");
    push(e0 + 17, 1'b1, 1'b1, "R7");
    drain();
    chk_reg(A_COUNT, 32'h0001_0006, "R8");
    chk_reg(A_MODE, 32'h0000_1504, "R7");
    wr(A_MODE, 32'h0, e);
    wr(A_STATUS, 32'h1, e);

    // R11 stop part way, restart full period, P=2 C=4
    wr(A_COUNT, {16'd2, 16'd4}, e);
    wr(A_MODE, 32'h0000_1104, e);
    repeat (2) @(posedge clk_i);
    wr(A_MODE, 32'h0000_0104, es);
    push(e + 8, 1'b0, 1'b0, "R11");
    push(e + 12, 1'b0, 1'b0, "R11");
    drain();
    wr(A_MODE, 32'h0000_1104, er);
    push(er + 7, 1'b0, 1'b0, "R11");
    push(er + 8, 1'b1, 1'b1, "R11");
    drain();
    wr(A_STATUS, 32'h1, e);

    // R4 prescaler zero -> 65536
    wr(A_COUNT, {16'd0, 16'd1}, e);
    wr(A_MODE, 32'h0000_1104, e);
    push(e + 65535, 1'b0, 1'b0, "R4");
    push(e + 65536, 1'b1, 1'b1, "R4");
    drain();
    wr(A_STATUS, 32'h1, e);

    // R5 period zero -> 65536 ticks
    wr(A_COUNT, {16'd1, 16'd0}, e);
    wr(A_MODE, 32'h0000_1104, e);
    push(e + 65535, 1'b0, 1'b0, "R5");
    push(e + 65536, 1'b1, 1'b1, "R5");
    drain();

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule